// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block performs the hardware side of taking an exception or interrupt in a small 32-bit CPU core. The core presents a request as a four-bit cause mask, covering trap/break, non-maskable interrupt, bus fault and external interrupt. Each cause comes with its own vector source. The block accepts one request when it is idle. It picks the winning cause and its vector, and it computes every piece of saved context in the acceptance cycle:

- the return address, adjusted for a pending branch delay slot;
- the target return register;
- the stack pointer swap;
- the shifted status word;
- the exception status word.

The block then reads the handler address from the vector table through a simple request/acknowledge memory read port. The word it reads becomes the new PC. All results are presented together on the one-cycle `done` strobe, and the core commits them into its register file on that strobe. That commit also ends any pending delay slot. A second bus fault that arrives while a bus-fault entry is still running is an illegal recursive fault. It raises a sticky abort flag.

Top module: `exc_entry_seq`

## Requirements
- R1: Cause mask bits are bit0 trap, bit1 NMI, bit2 bus fault, bit3 external interrupt. When several bits are set, bus fault wins over NMI, NMI wins over trap, and trap wins over external interrupt. The vector is `trap_vec` for a trap, `fault_vec` for a bus fault and `irq_vec` for an external interrupt. For an NMI the vector is always 0.
- R2: `ret_addr` equals `cur_pc` minus `ds_off`, where `ds_off` is the pending delay-slot offset and 0 means no delay slot. `ret_nmi` is 1 only for an NMI entry, which selects the NMI return register. For every other cause it is 0, which selects the exception return register.
- R3: `exs_out` carries the low 8 bits of the chosen vector in bits 15:8, and every other bit is zero.
- R4: If bit 8 of `cur_ccs` (user mode) is set, `sp_swap` is 1 and `sp_out` equals `kern_sp`. Otherwise `sp_swap` is 0 and `sp_out` equals `cur_sp`. In both cases `usp_out` equals `cur_sp`.
- R5: `ccs_out` keeps bits 31:30 of the status word and moves bits 19:0 up to 29:10. Bits 9:0 are zero, so the user-mode bit is cleared. For an NMI, bit 30 (the M flag) is cleared before the shift.
- R6: `mem_addr` equals `vec_base` plus 4 times the vector, with bit 31 (the cache-select bit) forced to 0. `mem_req` rises in the cycle after acceptance and holds, with `mem_addr` stable, until `mem_ack` is seen.
- R7: On the edge where `mem_ack` is sampled high, `pc_out` takes `mem_rdata`. In the following cycle `done` is 1 for exactly one cycle and `busy` is 0. `busy` is 1 from the cycle after acceptance until then.
- R8: A request presented while busy is ignored: it does not change the current entry and it is not started afterwards.
- R9: A bus-fault request that arrives while a bus-fault entry is busy sets `abort`. `abort` stays set until reset. A bus-fault request during any other kind of entry does not set it.
- R10: The synchronous active-high reset returns the block to idle with `busy`, `done`, `abort` and `mem_req` all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cause | input | 4 | Cause mask (bit0 trap, bit1 NMI, bit2 bus fault, bit3 external irq) |
| trap_vec | input | 8 | Vector for trap/break |
| fault_vec | input | 8 | Vector from address translation for a bus fault |
| irq_vec | input | 8 | Vector from the interrupt controller |
| cur_pc | input | 32 | PC at the faulting point |
| cur_sp | input | 32 | Current stack pointer |
| kern_sp | input | 32 | Kernel stack pointer |
| cur_ccs | input | 32 | Current status word |
| vec_base | input | 32 | Vector table base |
| ds_off | input | 2 | Pending delay-slot offset, 0 if none |
| busy | output | 1 | Entry in progress |
| done | output | 1 | One-cycle commit strobe |
| abort | output | 1 | Sticky recursive bus fault flag |
| mem_req | output | 1 | Vector table read request |
| mem_addr | output | 32 | Vector table read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data (handler address) |
| ret_addr | output | 32 | Return address to save |
| ret_nmi | output | 1 | 1: save into the NMI return register, 0: exception return register |
| sp_swap | output | 1 | Stack pointers are swapped |
| usp_out | output | 32 | Value for the user stack pointer register |
| sp_out | output | 32 | New stack pointer |
| ccs_out | output | 32 | New status word |
| exs_out | output | 32 | New exception status word |
| pc_out | output | 32 | Handler address for the PC |

## Verification
The main path is exercised with each cause alone and with several mixed cause masks, which distinguishes the priority order from a simple lowest-bit pick. Status words are chosen with user mode both set and clear, and with the M flag set, so a missing swap, a wrong shift window or an uncleared flag each shows up in a different output. Delay-slot offsets of 0, 1 and 2 separate the saved-address adjustment from the plain PC. A vector base with bit 31 set exposes a missing cache-bit clear. Requests raised while busy, including a second bus fault, distinguish ignoring a request from restarting on it and from a recursive abort.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CAUSE_N  = 4;
  localparam int TRAP_IDX = 0;
  localparam int NMI_IDX  = 1;
  localparam int BUSF_IDX = 2;
  localparam int IRQ_IDX  = 3;

  typedef enum logic [1:0] {
    CS_TRAP = 2'd0,
    CS_NMI  = 2'd1,
    CS_BUSF = 2'd2,
    CS_IRQ  = 2'd3
  } exc_cause_e;

  typedef enum logic {
    FS_IDLE  = 1'b0,
    FS_FETCH = 1'b1
  } fetch_st_e;

endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
  import exc_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [CAUSE_N-1:0] req_cause,
  input  logic [VEC_W-1:0]   trap_vec,
  input  logic [VEC_W-1:0]   fault_vec,
  input  logic [VEC_W-1:0]   irq_vec,
  output logic               any_req,
  output exc_cause_e         win_cause,
  output logic [VEC_W-1:0]   win_vec
);

  assign any_req = |req_cause;

  // Later tests override earlier ones: lowest priority first.
  always_comb begin
    win_cause = CS_IRQ;
    win_vec   = irq_vec;
    if (req_cause[TRAP_IDX]) begin
      win_cause = CS_TRAP;
      win_vec   = trap_vec;
    end
    if (req_cause[NMI_IDX]) begin
      win_cause = CS_NMI;
      win_vec   = '0;
    end
    if (req_cause[BUSF_IDX]) begin
      win_cause = CS_BUSF;
      win_vec   = fault_vec;
    end
  end

endmodule

// File: rtl/exc_ctx_xform.sv
module exc_ctx_xform
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int VEC_W     = 8,
  parameter int DS_W      = 2,
  parameter int U_BIT     = 8,
  parameter int M_BIT     = 30,
  parameter int CCS_KEEP  = 2,
  parameter int CCS_SHIFT = 10,
  parameter int EXS_POS   = 8,
  parameter int IDX_W     = 8
) (
  input  exc_cause_e        cause,
  input  logic [VEC_W-1:0]  vec,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sp,
  input  logic [XLEN-1:0]   kern_sp,
  input  logic [XLEN-1:0]   cur_ccs,
  input  logic [XLEN-1:0]   vec_base,
  input  logic [DS_W-1:0]   ds_off,
  output logic [XLEN-1:0]   ret_addr,
  output logic              ret_nmi,
  output logic              sp_swap,
  output logic [XLEN-1:0]   usp_val,
  output logic [XLEN-1:0]   sp_val,
  output logic [XLEN-1:0]   ccs_val,
  output logic [XLEN-1:0]   exs_val,
  output logic [XLEN-1:0]   fetch_addr
);

  localparam int LOW_W = XLEN - CCS_KEEP - CCS_SHIFT;

  logic [XLEN-1:0] vec_ext;
  logic [XLEN-1:0] ccs_pre;
  logic [XLEN-1:0] tbl_sum;

  assign vec_ext  = XLEN'(vec);
  assign ret_addr = cur_pc - XLEN'(ds_off);
  assign ret_nmi  = (cause == CS_NMI);

  assign sp_swap  = cur_ccs[U_BIT];
  assign usp_val  = cur_sp;
  assign sp_val   = sp_swap ? kern_sp : cur_sp;

  always_comb begin
    ccs_pre = cur_ccs;
    if (cause == CS_NMI) ccs_pre[M_BIT] = 1'b0;
  end

  assign ccs_val = {ccs_pre[XLEN-1 -: CCS_KEEP], ccs_pre[LOW_W-1:0],
                    {CCS_SHIFT{1'b0}}};

  always_comb begin
    exs_val = '0;
    exs_val[EXS_POS +: IDX_W] = vec_ext[IDX_W-1:0];
  end

  // Word-sized table entries; the top address bit only selects caching.
  assign tbl_sum = vec_base + (vec_ext << 2);
  always_comb begin
    fetch_addr = tbl_sum;
    fetch_addr[XLEN-1] = 1'b0;
  end

endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [XLEN-1:0] start_addr,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            busy,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  output logic            done,
  output logic [XLEN-1:0] pc_out
);

  fetch_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= FS_IDLE;
      busy     <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      pc_out   <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        FS_IDLE: begin
          if (start) begin
            st_q     <= FS_FETCH;
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            mem_addr <= start_addr;
          end
        end
        FS_FETCH: begin
          if (mem_ack) begin
            st_q    <= FS_IDLE;
            busy    <= 1'b0;
            mem_req <= 1'b0;
            done    <= 1'b1;
            pc_out  <= mem_rdata;
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R6
  AST_ADDR_NOCACHE: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !mem_addr[XLEN-1]); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req)); // R7

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8,
  parameter int DS_W  = 2,
  parameter int U_BIT = 8,
  parameter int M_BIT = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CAUSE_N-1:0] req_cause,
  input  logic [VEC_W-1:0]   trap_vec,
  input  logic [VEC_W-1:0]   fault_vec,
  input  logic [VEC_W-1:0]   irq_vec,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [XLEN-1:0]    cur_sp,
  input  logic [XLEN-1:0]    kern_sp,
  input  logic [XLEN-1:0]    cur_ccs,
  input  logic [XLEN-1:0]    vec_base,
  input  logic [DS_W-1:0]    ds_off,
  output logic               busy,
  output logic               done,
  output logic               abort,
  output logic               mem_req,
  output logic [XLEN-1:0]    mem_addr,
  input  logic               mem_ack,
  input  logic [XLEN-1:0]    mem_rdata,
  output logic [XLEN-1:0]    ret_addr,
  output logic               ret_nmi,
  output logic               sp_swap,
  output logic [XLEN-1:0]    usp_out,
  output logic [XLEN-1:0]    sp_out,
  output logic [XLEN-1:0]    ccs_out,
  output logic [XLEN-1:0]    exs_out,
  output logic [XLEN-1:0]    pc_out
);

  logic             any_req;
  exc_cause_e       win_cause;
  logic [VEC_W-1:0] win_vec;
  logic             accept;
  exc_cause_e       act_cause_q;

  logic [XLEN-1:0]  x_ret, x_usp, x_sp, x_ccs, x_exs, x_addr;
  logic             x_nmi, x_swap;

  exc_cause_arb #(.VEC_W(VEC_W)) u_arb (
    .req_cause (req_cause),
    .trap_vec  (trap_vec),
    .fault_vec (fault_vec),
    .irq_vec   (irq_vec),
    .any_req   (any_req),
    .win_cause (win_cause),
    .win_vec   (win_vec)
  );

  exc_ctx_xform #(
    .XLEN(XLEN), .VEC_W(VEC_W), .DS_W(DS_W), .U_BIT(U_BIT), .M_BIT(M_BIT)
  ) u_xform (
    .cause      (win_cause),
    .vec        (win_vec),
    .cur_pc     (cur_pc),
    .cur_sp     (cur_sp),
    .kern_sp    (kern_sp),
    .cur_ccs    (cur_ccs),
    .vec_base   (vec_base),
    .ds_off     (ds_off),
    .ret_addr   (x_ret),
    .ret_nmi    (x_nmi),
    .sp_swap    (x_swap),
    .usp_val    (x_usp),
    .sp_val     (x_sp),
    .ccs_val    (x_ccs),
    .exs_val    (x_exs),
    .fetch_addr (x_addr)
  );

  assign accept = any_req && !busy;

  exc_vec_fetch #(.XLEN(XLEN)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .start_addr (x_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .done       (done),
    .pc_out     (pc_out)
  );

  // Context is frozen at acceptance and committed by the core on done.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_cause_q <= CS_IRQ;
      ret_addr    <= '0;
      ret_nmi     <= 1'b0;
      sp_swap     <= 1'b0;
      usp_out     <= '0;
      sp_out      <= '0;
      ccs_out     <= '0;
      exs_out     <= '0;
    end else if (accept) begin
      act_cause_q <= win_cause;
      ret_addr    <= x_ret;
      ret_nmi     <= x_nmi;
      sp_swap     <= x_swap;
      usp_out     <= x_usp;
      sp_out      <= x_sp;
      ccs_out     <= x_ccs;
      exs_out     <= x_exs;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) abort <= 1'b0;
    else if (busy && (act_cause_q == CS_BUSF) && req_cause[BUSF_IDX])
      abort <= 1'b1;
  end

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (rst)
    abort |=> abort); // R9
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(exs_out) && $stable(ret_addr) && $stable(ccs_out))); // R8
  AST_EXS_ZERO: assert property (@(posedge clk) disable iff (rst)
    done |-> (exs_out[7:0] == 8'h00 && exs_out[XLEN-1:16] == '0)); // R3
  AST_CCS_LOW: assert property (@(posedge clk) disable iff (rst)
    done |-> (ccs_out[9:0] == 10'h000)); // R5

endmodule

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/100ps
module exc_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  req_cause;
  logic [7:0]  trap_vec, fault_vec, irq_vec;
  logic [31:0] cur_pc, cur_sp, kern_sp, cur_ccs, vec_base;
  logic [1:0]  ds_off;
  logic        busy, done, abort, mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic [31:0] ret_addr, usp_out, sp_out, ccs_out, exs_out, pc_out;
  logic        ret_nmi, sp_swap;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst(rst), .req_cause(req_cause),
    .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec),
    .cur_pc(cur_pc), .cur_sp(cur_sp), .kern_sp(kern_sp), .cur_ccs(cur_ccs),
    .vec_base(vec_base), .ds_off(ds_off),
    .busy(busy), .done(done), .abort(abort),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ret_addr(ret_addr), .ret_nmi(ret_nmi), .sp_swap(sp_swap),
    .usp_out(usp_out), .sp_out(sp_out), .ccs_out(ccs_out), .exs_out(exs_out),
    .pc_out(pc_out)
  );

  typedef struct packed {
    logic [3:0]  m;
    logic [7:0]  tv, fv, iv;
    logic [31:0] pc, sp, ksp, ccs, ebp;
    logic [1:0]  ds;
    logic [31:0] rd;
    logic [3:0]  wait_n;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{4'b0001, 8'h25, 8'h11, 8'h22, 32'h0000_1000, 32'h0000_7F00, 32'h0000_9F00,
      32'h0000_0000, 32'h0000_8000, 2'd0, 32'h0000_4000, 4'd0},
    '{4'b0010, 8'h25, 8'h11, 8'h22, 32'h0001_2344, 32'h1000_0000, 32'h2000_0000,
      32'hC00A_5155, 32'h0000_8000, 2'd2, 32'h0000_4400, 4'd2},
    '{4'b0100, 8'h33, 8'hF3, 8'h22, 32'h0002_0000, 32'h3000_0010, 32'h4000_0020,
      32'h4000_0100, 32'h8000_2000, 2'd0, 32'h0000_5000, 4'd1},
    '{4'b1000, 8'h33, 8'h44, 8'h81, 32'h0000_0001, 32'h0000_0100, 32'h0000_0200,
      32'h0000_0000, 32'h0000_0000, 2'd1, 32'hDEAD_BEE0, 4'd3},
    '{4'b1111, 8'h01, 8'h02, 8'h03, 32'h0000_A000, 32'h0000_0100, 32'h0000_0200,
      32'h0000_0100, 32'h0001_0000, 2'd0, 32'h0000_6000, 4'd0},
    '{4'b1011, 8'h01, 8'h02, 8'h03, 32'h0000_B000, 32'h0000_0100, 32'h0000_0200,
      32'h7FFF_FEFF, 32'h0001_0000, 2'd1, 32'h0000_7000, 4'd1},
    '{4'b1001, 8'h5A, 8'h02, 8'hA5, 32'h0000_C000, 32'h0000_0300, 32'h0000_0400,
      32'hFFFF_FFFF, 32'hFFFF_FF00, 2'd3, 32'h0000_8000, 4'd0}
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Expected-result model written from the requirements.
  function automatic logic [7:0] m_vec(vec_t v);
    if (v.m[2]) return v.fv;
    if (v.m[1]) return 8'h00;
    if (v.m[0]) return v.tv;
    return v.iv;
  endfunction

  function automatic logic [31:0] m_ccs(vec_t v);
    logic [31:0] c = v.ccs;
    if (v.m[2:1] == 2'b01) c[30] = 1'b0;
    return {c[31:30], c[19:0], 10'b0};
  endfunction

  function automatic logic [31:0] m_addr(vec_t v);
    logic [31:0] a = v.ebp + {22'b0, m_vec(v), 2'b00};
    a[31] = 1'b0;
    return a;
  endfunction

  task automatic idle_inputs();
    req_cause = 4'b0; mem_ack = 1'b0; mem_rdata = '0;
  endtask

  task automatic run_entry(vec_t v, input string tag);
    logic is_nmi;
    is_nmi = (v.m[2:1] == 2'b01);
    @(negedge clk);
    req_cause = v.m; trap_vec = v.tv; fault_vec = v.fv; irq_vec = v.iv;
    cur_pc = v.pc; cur_sp = v.sp; kern_sp = v.ksp; cur_ccs = v.ccs;
    vec_base = v.ebp; ds_off = v.ds;
    @(negedge clk);
    req_cause = 4'b0;
    chk({"R7 ", tag}, "busy", {31'b0, busy}, 32'd1);
    chk({"R6 ", tag}, "mem_req", {31'b0, mem_req}, 32'd1);
    chk({"R1 R6 ", tag}, "mem_addr", mem_addr, m_addr(v));
    for (int k = 0; k < int'(v.wait_n); k++) begin
      @(negedge clk);
      chk({"R6 ", tag}, "mem_req held", {31'b0, mem_req}, 32'd1);
    end
    mem_ack = 1'b1; mem_rdata = v.rd;
    @(negedge clk);
    mem_ack = 1'b0;
    chk({"R7 ", tag}, "done", {31'b0, done}, 32'd1);
    chk({"R7 ", tag}, "busy at done", {31'b0, busy}, 32'd0);
    chk({"R7 ", tag}, "pc_out", pc_out, v.rd);
    chk({"R2 ", tag}, "ret_addr", ret_addr, v.pc - {30'b0, v.ds});
    chk({"R2 ", tag}, "ret_nmi", {31'b0, ret_nmi}, {31'b0, is_nmi});
    chk({"R3 ", tag}, "exs_out", exs_out, {16'b0, m_vec(v), 8'b0});
    chk({"R4 ", tag}, "sp_swap", {31'b0, sp_swap}, {31'b0, v.ccs[8]});
    chk({"R4 ", tag}, "usp_out", usp_out, v.sp);
    chk({"R4 ", tag}, "sp_out", sp_out, v.ccs[8] ? v.ksp : v.sp);
    chk({"R5 ", tag}, "ccs_out", ccs_out, m_ccs(v));
    @(negedge clk);
    chk({"R7 ", tag}, "done one cycle", {31'b0, done}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    vec_t d;
    idle_inputs();
    trap_vec = '0; fault_vec = '0; irq_vec = '0; cur_pc = '0; cur_sp = '0;
    kern_sp = '0; cur_ccs = '0; vec_base = '0; ds_off = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10", "busy", {31'b0, busy}, 32'd0);
    chk("R10", "done", {31'b0, done}, 32'd0);
    chk("R10", "abort", {31'b0, abort}, 32'd0);
    chk("R10", "mem_req", {31'b0, mem_req}, 32'd0);

    for (int i = 0; i < NV; i++) run_entry(TBL[i], $sformatf("vec%0d", i));

    // R8: requests while busy are ignored; R9: bus fault during trap no abort
    d = TBL[0];
    d.tv = 8'h10; d.wait_n = 4'd0;
    @(negedge clk);
    req_cause = 4'b0001; trap_vec = 8'h10; vec_base = 32'h0000_8000; cur_ccs = '0;
    cur_pc = 32'h100; ds_off = 2'd0;
    @(negedge clk);
    req_cause = 4'b1110; irq_vec = 8'h77; fault_vec = 8'h66;
    @(negedge clk);
    req_cause = 4'b0;
    chk("R8", "mem_addr kept", mem_addr, 32'h0000_8040);
    chk("R9", "no abort on non-bus entry", {31'b0, abort}, 32'd0);
    mem_ack = 1'b1; mem_rdata = 32'h0000_0ABC;
    @(negedge clk);
    mem_ack = 1'b0;
    chk("R8", "exs of first entry", exs_out, 32'h0000_1000);
    chk("R8", "pc of first entry", pc_out, 32'h0000_0ABC);
    @(negedge clk);
    chk("R8", "no late start", {31'b0, busy}, 32'd0);
    chk("R8", "no late req", {31'b0, mem_req}, 32'd0);

    // R9: recursive bus fault
    @(negedge clk);
    req_cause = 4'b0100; fault_vec = 8'h09; vec_base = 32'h0;
    @(negedge clk);
    req_cause = 4'b0100;
    @(negedge clk);
    req_cause = 4'b0;
    chk("R9", "abort set", {31'b0, abort}, 32'd1);
    mem_ack = 1'b1; mem_rdata = 32'h1234;
    @(negedge clk);
    mem_ack = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "abort sticky", {31'b0, abort}, 32'd1);

    // R10: reset clears abort and a running fetch
    req_cause = 4'b0001;
    @(negedge clk);
    req_cause = 4'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10", "abort after reset", {31'b0, abort}, 32'd0);
    chk("R10", "busy after reset", {31'b0, busy}, 32'd0);
    chk("R10", "mem_req after reset", {31'b0, mem_req}, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule